// File: doc/BRIEF.md
# HDLC Serial Receive Deframer

This block takes a bit-serial HDLC line, one bit per cycle in which `bit_en` is high, and turns it into a stream of octets. Each octet is stored in a small receive queue together with a two-bit code that gives its position in the frame and, for the final octet, whether the frame was received correctly. The block watches the raw line all the time for opening and closing flags, for aborts, for the go-ahead pattern and for an idle channel. It removes the zeros that the transmitter inserted, checks the 16-bit CRC-CCITT over each frame, and screens out frames that are too short.

The host drains the queue through a read port. `rd_data` and `rd_stat` always describe the entry at the head of the queue, and `rd_en` moves on to the next entry. The queue only shows entries from frames that have already ended, so the final status of a frame is settled before any of its octets can be read. The two frame-check octets are kept as the last two entries of every frame that is long enough to be checked. Address screening takes place downstream.

Top module: `hdlc_rx`

## Requirements
- R1: The raw pattern 0,1,1,1,1,1,1,0 (in time order) is a flag. Each flag gives a single-cycle pulse on `flag_det`, and it resets the octet alignment, so the next data bit after it is bit 0 (LSB) of a new octet.
- R2: The raw pattern 0 followed by seven 1s and then 0 gives a single-cycle pulse on `goahead_det`. Flags and frame data never produce this pulse.
- R3: `idle_det` goes high when fifteen or more consecutive raw 1s have been received. It goes low again on the next raw 0.
- R4: Inside a frame, a 0 that follows five consecutive data 1s is removed before octet assembly. Octets such as 0xFF and 0x7E therefore come through intact.
- R5: A frame that has fewer than 25 data bits between its flags writes nothing to the queue.
- R6: A frame that has 25 to 31 data bits writes exactly one entry: its first octet, with status code 11.
- R7: Status codes are 01 for the first octet, 00 for a middle octet, 10 for the last octet of a good frame and 11 for the last octet of a bad frame. A frame of 32 or more bits whose CRC register holds 0xF0B8 at the closing flag, and whose length is a whole number of octets, gets code 10 on its last entry.
- R8: A frame of 32 or more bits with a CRC mismatch gets code 11 on its last entry. Its earlier entries keep their codes 01 and 00.
- R9: Seven consecutive raw 1s abort the current frame. If the frame had 32 or more bits, the octets received so far are kept and the last one gets code 11. The receiver then ignores the line until the next flag.
- R10: `rd_valid` is low after reset and whenever the queue holds no completed entry. While `rd_valid` is high and `rd_en` is low, `rd_data` and `rd_stat` hold steady. A cycle with `rd_en` high moves the head to the next entry.
- R11: Octets are assembled LSB first, and they enter the queue in the order they were received.
- R12: The two frame-check octets are stored after the data octets, low octet first, as the last two entries of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Marks a cycle that carries a line bit |
| bit_in | input | 1 | Serial line bit |
| rd_en | input | 1 | Pops the head entry of the queue |
| rd_valid | output | 1 | The head entry holds a completed octet |
| rd_data | output | 8 | Octet at the head of the queue |
| rd_stat | output | 2 | Position/quality code of the head octet |
| flag_det | output | 1 | Pulse for each detected flag |
| goahead_det | output | 1 | Pulse for each detected go-ahead |
| idle_det | output | 1 | Idle channel (at least 15 ones) present |

## Verification
The assertions take for granted that the line comes from a legal transmitter: the data carries zero insertion, so no run of six 1s appears outside a flag, and successive flags are at least seven bit times apart. They also assume that `rst` is high at time zero. The stimulus respects this because every data bit goes through a stuffing task, and flags, aborts, the go-ahead and idle runs are sent as whole raw patterns. The single-pulse and exclusivity properties for the detectors rely on these spacing limits.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam logic [7:0]  FLAG_PAT   = 8'h7E;
    localparam logic [7:0]  ABORT_PAT  = 8'h7F;
    localparam logic [8:0]  GA_PAT     = 9'h0FE;
    localparam logic [15:0] CRC_INIT   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam logic [15:0] CRC_GOOD   = 16'hF0B8;
    localparam int unsigned STUFF_RUN  = 5;
    localparam int unsigned IDLE_ONES  = 15;
    localparam int unsigned KEEP_BITS  = 25;
    localparam int unsigned FULL_BITS  = 32;

    typedef enum logic [1:0] {
        ST_MID   = 2'b00,
        ST_FIRST = 2'b01,
        ST_GOOD  = 2'b10,
        ST_BAD   = 2'b11
    } stat_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_DROP,
        OP_SHORT,
        OP_COMMIT
    } close_op_e;

    typedef struct packed {
        logic dv;
        logic db;
        logic flag;
        logic abort;
    } bit_evt_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_POLY_R : 16'h0000);
    endfunction

endpackage

// File: rtl/hdlc_rx_bitproc.sv
module hdlc_rx_bitproc
    import hdlc_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  logic     bit_in,
    output bit_evt_t evt,
    output logic     ga_det,
    output logic     idle_det
);

    localparam logic [3:0] SKIP_LEN = 4'd8;

    logic [7:0] sh;
    logic [8:0] win;
    logic [3:0] skip;
    logic [2:0] o_ones;
    logic [3:0] r_ones;
    logic       flag1, abort1;
    logic       out_b, drop0;
    logic       is_flag, is_abort, is_ga;

    assign win      = {sh, bit_in};
    assign is_flag  = (win[7:0] == FLAG_PAT);
    assign is_abort = (win[7:0] == ABORT_PAT);
    assign is_ga    = (win == GA_PAT);
    assign out_b    = sh[7];
    assign drop0    = !out_b && (o_ones == 3'(STUFF_RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            skip     <= '0;
            o_ones   <= '0;
            r_ones   <= '0;
            flag1    <= 1'b0;
            abort1   <= 1'b0;
            evt      <= '0;
            ga_det   <= 1'b0;
            idle_det <= 1'b0;
        end else begin
            evt.dv    <= 1'b0;
            evt.flag  <= flag1;
            evt.abort <= abort1;
            flag1     <= 1'b0;
            abort1    <= 1'b0;
            ga_det    <= 1'b0;
            if (bit_en) begin
                sh       <= win[7:0];
                r_ones   <= bit_in ? ((r_ones == 4'hF) ? 4'hF : r_ones + 4'd1) : 4'd0;
                idle_det <= bit_in && (r_ones >= 4'(IDLE_ONES - 1));
                ga_det   <= is_ga;
                flag1    <= is_flag;
                abort1   <= is_abort;
                if (skip != 4'd0) begin
                    skip   <= skip - 4'd1;
                    o_ones <= '0;
                end else begin
                    evt.dv <= !drop0;
                    evt.db <= out_b;
                    o_ones <= out_b ? ((o_ones == 3'd7) ? 3'd7 : o_ones + 3'd1) : 3'd0;
                end
                if (is_flag) begin
                    skip <= SKIP_LEN;
                end
            end
        end
    end

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned LEN_W = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  bit_evt_t  evt,
    input  logic      fifo_full,
    output logic      push,
    output logic [7:0] push_data,
    output stat_e     push_stat,
    output close_op_e op,
    output stat_e     fix_stat
);

    localparam logic [LEN_W-1:0] LEN_MAX  = '1;
    localparam logic [LEN_W-1:0] KEEP_LEN = LEN_W'(KEEP_BITS);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(FULL_BITS);
    localparam logic [LEN_W-1:0] OCT_LEN  = LEN_W'(8);

    logic             infr;
    logic             ovf;
    logic [7:0]       sr;
    logic [2:0]       bidx;
    logic [LEN_W-1:0] nbits;
    logic [15:0]      crc;

    always_comb begin
        push      = 1'b0;
        push_data = {evt.db, sr[7:1]};
        push_stat = (nbits < OCT_LEN) ? ST_FIRST : ST_MID;
        op        = OP_NONE;
        fix_stat  = ST_BAD;
        if (infr && (evt.flag || evt.abort)) begin
            if (nbits < KEEP_LEN)      op = OP_DROP;
            else if (nbits < FULL_LEN) op = OP_SHORT;
            else                       op = OP_COMMIT;
            if (evt.flag && (crc == CRC_GOOD) && (bidx == 3'd0) && !ovf)
                fix_stat = ST_GOOD;
        end else if (infr && evt.dv && (bidx == 3'd7)) begin
            push = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            infr  <= 1'b0;
            ovf   <= 1'b0;
            sr    <= '0;
            bidx  <= '0;
            nbits <= '0;
            crc   <= CRC_INIT;
        end else if (evt.flag) begin
            infr  <= 1'b1;
            ovf   <= 1'b0;
            bidx  <= '0;
            nbits <= '0;
            crc   <= CRC_INIT;
        end else if (evt.abort) begin
            infr <= 1'b0;
        end else if (infr && evt.dv) begin
            crc  <= crc_step(crc, evt.db);
            sr   <= {evt.db, sr[7:1]};
            bidx <= bidx + 3'd1;
            if (nbits != LEN_MAX) nbits <= nbits + 1'b1;
            if (push && fifo_full) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [7:0] push_data,
    input  stat_e      push_stat,
    input  close_op_e  op,
    input  stat_e      fix_stat,
    input  logic       pop,
    output logic       full,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic [1:0] rd_stat
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    logic [7:0]    mem  [DEPTH];
    stat_e         stm  [DEPTH];
    logic [PW-1:0] wptr, cptr, rptr, last_ptr;
    logic          have_open, do_push;

    assign full      = ((wptr - rptr) == PW'(DEPTH));
    assign have_open = (wptr != cptr);
    assign last_ptr  = wptr - PW'(1);
    assign do_push   = push && !full;
    assign rd_valid  = (cptr != rptr);
    assign rd_data   = mem[rptr[AW-1:0]];
    assign rd_stat   = stm[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            cptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) wptr <= wptr + PW'(1);
            case (op)
                OP_DROP:  wptr <= cptr;
                OP_SHORT: if (have_open) begin
                    wptr <= cptr + PW'(1);
                    cptr <= cptr + PW'(1);
                end
                OP_COMMIT: if (have_open) cptr <= wptr;
                default: ;
            endcase
            if (pop && rd_valid) rptr <= rptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr[AW-1:0]] <= push_data;
            stm[wptr[AW-1:0]] <= push_stat;
        end
        if (op == OP_SHORT && have_open) stm[cptr[AW-1:0]] <= ST_BAD;
        if (op == OP_COMMIT && have_open) stm[last_ptr[AW-1:0]] <= fix_stat;
    end

endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned LEN_W      = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       rd_en,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic [1:0] rd_stat,
    output logic       flag_det,
    output logic       goahead_det,
    output logic       idle_det
);

    bit_evt_t   evt;
    logic       push, full;
    logic [7:0] push_data;
    stat_e      push_stat, fix_stat;
    close_op_e  op;

    hdlc_rx_bitproc u_bits (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .evt      (evt),
        .ga_det   (goahead_det),
        .idle_det (idle_det)
    );

    assign flag_det = evt.flag;

    hdlc_rx_framer #(.LEN_W(LEN_W)) u_frm (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .fifo_full (full),
        .push      (push),
        .push_data (push_data),
        .push_stat (push_stat),
        .op        (op),
        .fix_stat  (fix_stat)
    );

    hdlc_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_q (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .push_stat (push_stat),
        .op        (op),
        .fix_stat  (fix_stat),
        .pop       (rd_en),
        .full      (full),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_stat   (rd_stat)
    );

endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic       bit_in,
    input logic       rd_en,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic [1:0] rd_stat,
    input logic       flag_det,
    input logic       goahead_det,
    input logic       idle_det
);

    // R10
    reset_empty_chk: assert property (@(posedge clk) rst |=> !rd_valid);

    // R10
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data) && $stable(rd_stat)));

    // R1
    flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        flag_det |=> !flag_det);

    // R3
    idle_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_det) |-> ($past(bit_en) && $past(bit_in)));

    // R3
    idle_flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        flag_det |-> !idle_det);

    // R2
    ga_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
        goahead_det |-> ($past(bit_en) && !$past(bit_in) && !flag_det));

endmodule

bind hdlc_rx hdlc_rx_chk u_chk (.*);

// File: tb/tb_hdlc_rx.sv
module tb_hdlc_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_valid, flag_det, goahead_det, idle_det;
    logic [7:0] rd_data;
    logic [1:0] rd_stat;

    always #10 clk = ~clk;

    hdlc_rx dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_stat(rd_stat),
        .flag_det(flag_det), .goahead_det(goahead_det), .idle_det(idle_det)
    );

    int total = 0, bad = 0, ones_run = 0, flag_cnt = 0, ga_cnt = 0;

    localparam int NV = 8;
    localparam int         VN    [NV] = '{2, 3, 4, 5, 3, 6, 1, 4};
    localparam logic [7:0] VSEED [NV] = '{8'h11, 8'hAA, 8'hFF, 8'h7E, 8'h3C, 8'h01, 8'h55, 8'hF0};
    localparam logic [7:0] VSTEP [NV] = '{8'h22, 8'h00, 8'h00, 8'h01, 8'h05, 8'h33, 8'h00, 8'h0F};
    localparam bit         VBAD  [NV] = '{0, 0, 0, 0, 1, 0, 0, 1};

    always @(negedge clk) begin
        if (flag_det) flag_cnt++;
        if (goahead_det) ga_cnt++;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] v);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ v[i]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic tx_bit(input logic b);
        send_bit(b);
        if (b) begin
            ones_run++;
            if (ones_run == 5) begin
                send_bit(1'b0);
                ones_run = 0;
            end
        end else begin
            ones_run = 0;
        end
    endtask

    task automatic tx_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) tx_bit(v[i]);
    endtask

    task automatic send_flag();
        send_bit(1'b0);
        repeat (6) send_bit(1'b1);
        send_bit(1'b0);
        ones_run = 0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_entry(input logic [7:0] d, input logic [1:0] s, input string tag);
        @(negedge clk);
        check(rd_valid == 1'b1, tag, "rd_valid", int'(rd_valid), 1);
        check(rd_data == d, tag, "rd_data", int'(rd_data), int'(d));
        check(rd_stat == s, tag, "rd_stat", int'(rd_stat), int'(s));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        @(negedge clk);
        check(rd_valid == 1'b0, tag, "queue empty", int'(rd_valid), 0);
    endtask

    task automatic send_short(input int extra, input logic [7:0] b0);
        send_flag();
        tx_byte(b0);
        tx_byte(8'hC3);
        tx_byte(8'h5A);
        for (int i = 0; i < extra; i++) tx_bit(1'b0);
        send_flag();
        settle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check(rd_valid == 1'b0, "R10", "rd_valid in reset", int'(rd_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_valid == 1'b0, "R10", "rd_valid after reset", int'(rd_valid), 0);
        check(idle_det == 1'b0, "R3", "idle after reset", int'(idle_det), 0);
        check(flag_det == 1'b0, "R1", "flag after reset", int'(flag_det), 0);

        // table of frames
        for (int v = 0; v < NV; v++) begin
            logic [7:0]  bytes [8];
            logic [15:0] c;
            logic [15:0] fcs;
            int          f0;
            int          n;
            n = VN[v];
            c = 16'hFFFF;
            for (int i = 0; i < n; i++) begin
                bytes[i] = VSEED[v] + 8'(i) * VSTEP[v];
                c = crc_byte(c, bytes[i]);
            end
            fcs = ~c;
            if (VBAD[v]) fcs[0] = ~fcs[0];
            bytes[n]     = fcs[7:0];
            bytes[n + 1] = fcs[15:8];
            f0 = flag_cnt;
            send_flag();
            for (int i = 0; i < n + 2; i++) tx_byte(bytes[i]);
            send_flag();
            settle();
            check(flag_cnt - f0 == 2, "R1", "flag pulses", flag_cnt - f0, 2);
            if (n >= 2) begin
                for (int i = 0; i < n + 2; i++) begin
                    if (i == 0)          expect_entry(bytes[i], 2'b01, "R11");
                    else if (i == n + 1) expect_entry(bytes[i], VBAD[v] ? 2'b11 : 2'b10,
                                                      VBAD[v] ? "R8" : "R7");
                    else if (i == n)     expect_entry(bytes[i], 2'b00, "R12");
                    else                 expect_entry(bytes[i], 2'b00, "R4");
                end
                expect_empty("R10");
            end else begin
                expect_empty("R5");
            end
        end
        check(ga_cnt == 0, "R2", "no go-ahead from frames", ga_cnt, 0);

        // length screening
        send_short(0, 8'h96);
        expect_empty("R5");
        send_short(1, 8'h96);
        expect_entry(8'h96, 2'b11, "R6");
        expect_empty("R6");
        send_short(7, 8'h3F);
        expect_entry(8'h3F, 2'b11, "R6");
        expect_empty("R6");

        // abort after five octets, then idle, then ignored data
        send_flag();
        for (int i = 0; i < 5; i++) tx_byte(8'h20 + 8'(i));
        send_bit(1'b0);
        repeat (16) send_bit(1'b1);
        repeat (2) @(negedge clk);
        check(idle_det == 1'b1, "R3", "idle after 16 ones", int'(idle_det), 1);
        ones_run = 0;
        for (int i = 0; i < 4; i++) tx_byte(8'h81 + 8'(i));
        send_flag();
        settle();
        check(idle_det == 1'b0, "R3", "idle cleared by zero", int'(idle_det), 0);
        for (int i = 0; i < 5; i++)
            expect_entry(8'h20 + 8'(i), (i == 0) ? 2'b01 : ((i == 4) ? 2'b11 : 2'b00), "R9");
        expect_empty("R9");

        // go-ahead
        begin
            int g0;
            g0 = ga_cnt;
            repeat (7) send_bit(1'b1);
            send_bit(1'b0);
            settle();
            check(ga_cnt - g0 == 1, "R2", "go-ahead pulses", ga_cnt - g0, 1);
        end
        send_flag();
        settle();
        expect_empty("R2");

        // pop on empty queue is harmless, next frame intact
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        begin
            logic [15:0] c;
            c = crc_byte(crc_byte(16'hFFFF, 8'hE7), 8'h18);
            c = ~c;
            send_flag();
            tx_byte(8'hE7);
            tx_byte(8'h18);
            tx_byte(c[7:0]);
            tx_byte(c[15:8]);
            send_flag();
            settle();
            expect_entry(8'hE7, 2'b01, "R10");
            expect_entry(8'h18, 2'b00, "R10");
            expect_entry(c[7:0], 2'b00, "R12");
            expect_entry(c[15:8], 2'b10, "R7");
            expect_empty("R10");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule